// File: doc/BRIEF.md
# Commit-Gated Multi-Ratio Clock Enable Generator

This block produces nine independent clock-enable strobes from one fast parent clock. Each strobe pulses for one parent cycle once per divided period. A 4-bit code picks each period from an irregular ratio table. The codes are packed into two 32-bit control words. A bus writes the codes into shadow registers. The live dividers keep their old ratios until software sets a self-clearing commit bit.

When the commit bit is set, every divider runs down to its terminal count and then waits there. On the first cycle in which all nine dividers are at terminal count, every strobe fires together and the shadow codes become live. On that same cycle the commit bit clears. Each field carries a legality mask. A code that the mask or the ratio table rejects is dropped, and a sticky error flag records the rejection. Reads always return the live codes, so software can confirm that a commit took effect.

Top module: `ratio_kick_div`

## Requirements
- R1: Code to period mapping: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48, 12→7 parent cycles. Code 9 and codes 13–15 are reserved.
- R2: Word 0 (sel=0) holds fields f0..f5 at bits [23:20], [19:16], [15:12], [11:8], [7:4] and [3:0]. Word 1 (sel=1) holds f6 at [27:24], f7 at [15:12] and f8 at [7:4]. Reads use the same positions.
- R3: A field accepts code n only if bit n of its mask is set and n is not reserved. The default masks are f0 0xdff, f1 0xd7f, f2 0x1dff, f3 0xdff, f4 0x1dff, f5 0x1dff, f6 0x97f, f7 0xdff and f8 0xdff. When a code is rejected, that field's shadow keeps its old value.
- R4: Any rejected code sets an error flag at word 1 bit 30. The flag stays set until reset.
- R5: Shadow codes do not affect the read data or the strobes until a commit completes. Reads return the live codes.
- R6: Writing word 1 with bit 31 set starts a commit. Bit 31 reads 1 while the commit is pending and clears by itself within 48 parent cycles.
- R7: A commit completes on a cycle in which all nine strobes pulse together. From that pulse onward, each divider runs at its new period.
- R8: A synchronous active-high reset sets all codes to 0 and clears the pending and error flags. Strobes are low in the first cycle after reset and high in the second.
- R9: Each strobe is high for exactly one parent cycle per period. It is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Word selected for write (0 or 1) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Word selected for read |
| rd_data | output | 32 | Live codes of the selected word; word 1 also carries the pending and error bits |
| clk_en | output | 9 | One-cycle enable strobes, bit i for field fi |

## Verification
A write takes effect at the clock edge on which it is sampled. Shadow state, the pending bit and the error bit are therefore visible on the read port at the next mid-cycle sample. The bench issues each read at a falling edge and compares it one time unit later. After a commit, the bench polls bit 31 every cycle and counts the cycles the bit stays set. It records the strobe vector in the last pending cycle, where all nine strobes must be high. Period checks wait for one pulse of the chosen strobe, require the next sample to be low, and count samples until the following pulse.

// File: rtl/rkd_pkg.sv
`timescale 1ns/1ps
package rkd_pkg;
  localparam int NUM_FIELDS = 9;
  localparam int CODE_W     = 4;
  localparam int MAX_RATIO  = 48;
  localparam int CNT_W      = $clog2(MAX_RATIO);

  // Ratio for a code; 0 marks a reserved code.
  function automatic logic [CNT_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
    case (c)
      4'd0:  code_ratio = 6'd2;
      4'd1:  code_ratio = 6'd3;
      4'd2:  code_ratio = 6'd4;
      4'd3:  code_ratio = 6'd6;
      4'd4:  code_ratio = 6'd8;
      4'd5:  code_ratio = 6'd12;
      4'd6:  code_ratio = 6'd16;
      4'd7:  code_ratio = 6'd18;
      4'd8:  code_ratio = 6'd24;
      4'd10: code_ratio = 6'd36;
      4'd11: code_ratio = 6'd48;
      4'd12: code_ratio = 6'd7;
      default: code_ratio = '0;
    endcase
  endfunction

  // Word holding field i.
  function automatic int field_word(input int i);
    return (i < 6) ? 0 : 1;
  endfunction

  // Lowest bit of field i inside its word.
  function automatic int field_lo(input int i);
    if (i < 6)       return 20 - 4 * i;
    else if (i == 6) return 24;
    else if (i == 7) return 12;
    else             return 4;
  endfunction
endpackage

// File: rtl/rkd_regs.sv
`timescale 1ns/1ps
module rkd_regs
  import rkd_pkg::*;
#(
  parameter logic [NUM_FIELDS-1:0][15:0] FIELD_MASK = '1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic                                 wr_sel,
  input  logic [31:0]                          wr_data,
  input  logic                                 commit_fire,
  output logic [NUM_FIELDS-1:0][CODE_W-1:0]    shadow,
  output logic [NUM_FIELDS-1:0][CODE_W-1:0]    live,
  output logic                                 pending,
  output logic                                 err,
  output logic                                 reject
);
  localparam int KICK_BIT = 31;

  logic [NUM_FIELDS-1:0] fld_reject;
  logic                  kick_wr;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int LO = field_lo(i);
    localparam int WD = field_word(i);
    logic              hit;
    logic [CODE_W-1:0] code;
    logic              legal;
    assign hit   = wr_en && (int'(wr_sel) == WD);
    assign code  = wr_data[LO +: CODE_W];
    assign legal = FIELD_MASK[i][code] && (code_ratio(code) != '0);
    assign fld_reject[i] = hit && !legal;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[i] <= '0;
        live[i]   <= '0;
      end else begin
        if (hit && legal) shadow[i] <= code;
        if (commit_fire)  live[i]   <= shadow[i];
      end
    end
  end

  assign reject  = |fld_reject;
  assign kick_wr = wr_en && wr_sel && wr_data[KICK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      err     <= 1'b0;
    end else begin
      pending <= (pending && !commit_fire) || kick_wr;
      if (reject) err <= 1'b1;
    end
  end
endmodule

// File: rtl/rkd_counter.sv
`timescale 1ns/1ps
module rkd_counter
  import rkd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [CNT_W-1:0] reload,
  output logic             at_zero,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign at_zero = (cnt == '0);
  assign tick    = at_zero && advance;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= CNT_W'(1);
    else if (!at_zero) cnt <= cnt - 1'b1;
    else if (advance)  cnt <= reload;
  end
endmodule

// File: rtl/ratio_kick_div.sv
`timescale 1ns/1ps
module ratio_kick_div
  import rkd_pkg::*;
#(
  parameter logic [NUM_FIELDS-1:0][15:0] FIELD_MASK = {
    16'h0dff, 16'h0dff, 16'h097f, 16'h1dff, 16'h1dff,
    16'h0dff, 16'h1dff, 16'h0d7f, 16'h0dff}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [31:0]           wr_data,
  input  logic                  rd_sel,
  output logic [31:0]           rd_data,
  output logic [NUM_FIELDS-1:0] clk_en
);
  logic [NUM_FIELDS-1:0][CODE_W-1:0] shadow;
  logic [NUM_FIELDS-1:0][CODE_W-1:0] live;
  logic [NUM_FIELDS*CODE_W-1:0]      live_flat;
  logic [NUM_FIELDS-1:0]             zero_vec;
  logic                              pending;
  logic                              err;
  logic                              reject;
  logic                              all_zero;
  logic                              advance;
  logic                              commit_fire;

  assign all_zero    = &zero_vec;
  assign commit_fire = pending && all_zero;
  assign advance     = !pending || all_zero;
  assign live_flat   = live;

  rkd_regs #(.FIELD_MASK(FIELD_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .commit_fire(commit_fire), .shadow(shadow), .live(live),
    .pending(pending), .err(err), .reject(reject)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_div
    logic [CNT_W-1:0] reload;
    assign reload = commit_fire ? code_ratio(shadow[i]) - 1'b1
                                : code_ratio(live[i]) - 1'b1;
    rkd_counter u_cnt (
      .clk(clk), .rst(rst), .advance(advance), .reload(reload),
      .at_zero(zero_vec[i]), .tick(clk_en[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (field_word(i) == int'(rd_sel))
        rd_data[field_lo(i) +: CODE_W] = live[i];
    end
    if (rd_sel) begin
      rd_data[31] = pending;
      rd_data[30] = err;
    end
  end
endmodule

// File: rtl/rkd_chk.sv
`timescale 1ns/1ps
module rkd_chk
  import rkd_pkg::*;
(
  input logic                         clk,
  input logic                         rst,
  input logic                         pending,
  input logic                         commit_fire,
  input logic                         err,
  input logic                         reject,
  input logic [NUM_FIELDS-1:0]        clk_en,
  input logic [NUM_FIELDS*CODE_W-1:0] live_flat
);
  localparam int KICK_LIMIT = MAX_RATIO;
  logic [CNT_W:0] pend_cnt;

  always_ff @(posedge clk) begin
    if (rst || !pending) pend_cnt <= '0;
    else                 pend_cnt <= pend_cnt + 1'b1;
  end

  p_kick_bound_r6: assert property (@(posedge clk) disable iff (rst)
    pending |-> (int'(pend_cnt) < KICK_LIMIT));

  p_commit_sync_r7: assert property (@(posedge clk) disable iff (rst)
    commit_fire |-> (&clk_en));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (($past(clk_en) & clk_en) == '0));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_reject_flag_r3: assert property (@(posedge clk) disable iff (rst)
    reject |=> err);

  p_live_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !commit_fire |=> $stable(live_flat));
endmodule

bind ratio_kick_div rkd_chk u_chk (
  .clk(clk), .rst(rst), .pending(pending), .commit_fire(commit_fire),
  .err(err), .reject(reject), .clk_en(clk_en), .live_flat(live_flat)
);

// File: tb/ratio_kick_div_test.sv
`timescale 1ns/1ps
module ratio_kick_div_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [8:0]  clk_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic        sel;
    logic [31:0] val;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  always #2.5 clk = ~clk;

  ratio_kick_div uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .clk_en(clk_en)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each queued read one time unit after a falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        rd_item_t it;
        it = sb.pop_front();
        check(rd_data === it.val, it.tag, rd_data, it.val);
      end
    end
  end

  task automatic exp_read(input logic sel, input logic [31:0] val, input string tag);
    rd_item_t it;
    rd_sel = sel;
    it.sel = sel; it.val = val; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  task automatic write_word(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Commit: write word 1 with bit 31, poll until it clears.
  task automatic kick(input logic [31:0] w1, input string tag);
    int n = 0;
    logic [8:0] last = '0;
    rd_sel = 1'b1;
    write_word(1'b1, w1 | 32'h8000_0000);
    while (rd_data[31] && n <= 60) begin
      last = clk_en;
      n++;
      @(negedge clk);
    end
    check(n >= 1 && n <= 48, {tag, " R6 kick clear latency"}, n, 48);
    check(last == 9'h1FF, {tag, " R7 all strobes on commit cycle"}, last, 9'h1FF);
  endtask

  task automatic period(input int f, input int exp, input string tag);
    int n = 0;
    int w = 0;
    while (!clk_en[f] && w < 200) begin w++; @(negedge clk); end
    @(negedge clk);
    check(clk_en[f] == 1'b0, {tag, " R9 one-cycle pulse"}, clk_en[f], 0);
    n = 1;
    while (!clk_en[f] && n < 200) begin n++; @(negedge clk); end
    check(n == exp, {tag, " R1 period"}, n, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state, strobes low then all high
    check(clk_en == 9'h000, "R8 first cycle strobes", clk_en, 0);
    @(negedge clk);
    check(clk_en == 9'h1FF, "R8 second cycle strobes", clk_en, 9'h1FF);
    exp_read(1'b0, 32'h0, "R8 word0 reset");
    exp_read(1'b1, 32'h0, "R8 word1 reset");

    // R5: shadow write is not visible before commit
    write_word(1'b0, 32'h0058_C1AB);
    exp_read(1'b0, 32'h0, "R5 live unchanged before commit");
    period(0, 2, "R5 f0 still old ratio");

    // R6/R7/R2: commit, read back live codes at field positions
    kick(32'h0200_3060, "commit1");
    exp_read(1'b0, 32'h0058_C1AB, "R2 word0 layout after commit");
    exp_read(1'b1, 32'h0200_3060, "R2 word1 layout after commit");

    // R1/R9: all ratios in use
    period(0, 12, "f0 code5");
    period(1, 24, "f1 code8");
    period(2, 7,  "f2 code12");
    period(3, 3,  "f3 code1");
    period(4, 36, "f4 code10");
    period(5, 48, "f5 code11");
    period(6, 4,  "f6 code2");
    period(7, 6,  "f7 code3");
    period(8, 16, "f8 code6");

    // R3/R4: code 12 rejected by f0 mask
    write_word(1'b0, 32'h00C8_C1AB);
    kick(32'h0200_3060, "commit2");
    exp_read(1'b0, 32'h0058_C1AB, "R3 masked code kept old value");
    exp_read(1'b1, 32'h4200_3060, "R4 error flag set");

    // R3: reserved code 9 and out-of-table 14 rejected
    write_word(1'b0, 32'h0058_9EAB);
    kick(32'h0200_3060, "commit3");
    exp_read(1'b0, 32'h0058_C1AB, "R3 reserved codes ignored");
    period(2, 7, "R3 f2 keeps ratio 7");

    // R3: narrow mask on f6 rejects code 7
    kick(32'h0700_3060, "commit4");
    exp_read(1'b1, 32'h4200_3060, "R3 narrow mask rejects code7");

    // R4 sticky across legal commit; f6 legal code 11
    kick(32'h0B00_3060, "commit5");
    exp_read(1'b1, 32'h4B00_3060, "R4 flag sticky after legal write");
    period(6, 48, "R7 f6 new ratio 48");

    // R8: reset clears codes and flags
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_read(1'b1, 32'h0, "R8 word1 after second reset");
    exp_read(1'b0, 32'h0, "R8 word0 after second reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule